// File: doc/BRIEF.md
# Interrupt Request Collector with Selectable Sources

This block gathers the interrupt sources of a small 8-bit processor and decides which one, if any, is presented to the CPU sequencer. Each of eight slots has a latched request bit and an enable bit. A global block flag gates every slot request. A software break request is the one request that the flag does not gate. Five of the slots can each take their events from one of two sources, chosen by a per-slot selection bit. Two slots are fed by external pins, and a single pin-select bit moves both of them from their first pin to their second pin.

External pins are brought into the clock domain through two flip-flops and detected on their rising edge. On-chip sources arrive as one-cycle strobes. The sequencer observes `irq_pending` together with `irq_index` and answers with `accept`. Acceptance clears the winning request bit and raises the block flag, so further interrupts stay out until software lowers the flag again. Separate strobes set the flag, clear it, and restore a saved value when an interrupt routine returns.

Software reaches the block through a 2-bit register port. Offset 0 holds the requests, offset 1 the enables, offset 2 the source selection, and offset 3 the configuration.

Top module: `irqc_top`

## Requirements
- R1: A selected source event sets its slot's request bit in the cycle that follows the event. The bit then holds until it is accepted or cleared.
- R2: A write to offset 0 clears every request bit whose data bit is 0. Data bits of 1 leave the request bit unchanged, so software can never raise a request.
- R3: The enable bits at offset 1 can be read and written freely. A request whose enable bit is 0 still latches, but it never drives `irq_pending`.
- R4: While `irq_block` is 1, no slot request is presented. While `brk_req` is 1, `irq_pending` and `irq_is_brk` are both 1 whatever the state of the flag.
- R5: `accept` while a slot request is presented clears that slot's request bit. An `accept` while `brk_req` is high clears no request bit. In both cases `irq_block` reads 1 on the next cycle.
- R6: When several strobes act on the block flag in one cycle, the result follows a fixed order. `accept` wins and forces 1. Next comes `flag_set`, which forces 1. Then `flag_clr`, which forces 0. Last comes `flag_restore`, which loads `flag_restore_val`.
- R7: Offset 2 bit n selects the source of shared slot n, for slots 0 to 4. A 0 selects the primary source and a 1 selects `src_alt[n]`. Bits 5 to 7 read 0 and have no effect. Slots 5 to 7 always take `src_main`.
- R8: The primary source of slot 0 is external pin 0, and the primary source of slot 3 is external pin 1. `src_main[0]` and `src_main[3]` are ignored. Offset 3 bit 6 chooses the pin: 0 uses `pin_a` and 1 uses `pin_b`. The other bits of offset 3 read 0.
- R9: A pin that rises before clock edge k sets its request bit at edge k+2. A falling pin sets nothing.
- R10: Among the requests that are both enabled and pending, the lowest slot index wins and is driven on `irq_index`.
- R11: A source event and a clear of the same request bit in the same cycle leave the bit at 1. This holds whether the clear comes from a software write or from an accept.
- R12: After reset, every request, enable and selection bit is 0, the pin select is 0, `irq_block` is 1 and `irq_pending` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_a | input | 2 | First external pin for slots 0 and 3 |
| pin_b | input | 2 | Second external pin for slots 0 and 3 |
| src_main | input | 8 | Primary on-chip event strobes, one per slot |
| src_alt | input | 8 | Alternate event strobes for shared slots 0 to 4 |
| brk_req | input | 1 | Software break request |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on `reg_addr` |
| accept | input | 1 | The sequencer takes the presented request |
| flag_set | input | 1 | Set the block flag |
| flag_clr | input | 1 | Clear the block flag |
| flag_restore | input | 1 | Load the block flag from `flag_restore_val` |
| flag_restore_val | input | 1 | Saved flag value to restore |
| irq_pending | output | 1 | A request is presented |
| irq_is_brk | output | 1 | The presented request is the break |
| irq_index | output | 3 | Winning slot index |
| irq_block | output | 1 | Global block flag |

## Verification
Two pairs of actions can fall on one request bit in the same clock edge. A source strobe can coincide with a software write of 0, and a source strobe can coincide with an accept of that same slot. The bench provokes both by driving the strobe and the write, or the strobe and the accept, in the same low phase of the clock. It then reads offset 0 back and expects the bit still set, while other bits that were cleared in that write stay cleared. The block flag is treated the same way: pairs of flag strobes are driven together, and the resulting flag value is compared with the order fixed in R6.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    RA_REQ = 2'd0,
    RA_EN  = 2'd1,
    RA_SEL = 2'd2,
    RA_CFG = 2'd3
  } reg_addr_e;

  // position of the pin-select bit in the configuration register
  localparam int unsigned CFG_PINSEL_BIT = 6;

  // number of set bits of m strictly below position pos
  function automatic int unsigned bits_below(input logic [31:0] m, input int unsigned pos);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if ((i < pos) && m[i]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_out = stage2_q;
endmodule

// File: rtl/irqc_pin_edge.sv
module irqc_pin_edge #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_raw,
  output logic [W-1:0] rise
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_raw;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/irqc_src_route.sv
module irqc_src_route import irqc_pkg::*; #(
  parameter int unsigned         NSLOT      = 8,
  parameter logic [NSLOT-1:0]    SHARE_MASK = 8'h1F,
  parameter logic [NSLOT-1:0]    EXT_MASK   = 8'h09,
  parameter int unsigned         NEXT       = 2
) (
  input  logic [NEXT-1:0]  rise_a,
  input  logic [NEXT-1:0]  rise_b,
  input  logic             pin_sel,
  input  logic [NSLOT-1:0] src_main,
  input  logic [NSLOT-1:0] src_alt,
  input  logic [NSLOT-1:0] sel_q,
  output logic [NSLOT-1:0] slot_evt
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic primary;
    if (EXT_MASK[s]) begin : g_ext
      localparam int unsigned J = bits_below(32'(EXT_MASK), s);
      assign primary = pin_sel ? rise_b[J] : rise_a[J];
    end else begin : g_int
      assign primary = src_main[s];
    end
    if (SHARE_MASK[s]) begin : g_shr
      assign slot_evt[s] = sel_q[s] ? src_alt[s] : primary;
    end else begin : g_ded
      assign slot_evt[s] = primary;
    end
  end

  logic unused_inputs;
  assign unused_inputs = ^(src_main & EXT_MASK) ^ ^(src_alt & ~SHARE_MASK) ^ ^(sel_q & ~SHARE_MASK);
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned NSLOT = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [NSLOT-1:0] cand,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |cand;
    idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (cand[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top import irqc_pkg::*; #(
  parameter int unsigned      NSLOT      = 8,
  parameter int unsigned      DATA_W     = 8,
  parameter logic [NSLOT-1:0] SHARE_MASK = 8'h1F,
  parameter logic [NSLOT-1:0] EXT_MASK   = 8'h09,
  localparam int unsigned     NEXT       = bits_below(32'(EXT_MASK), NSLOT),
  localparam int unsigned     IDX_W      = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEXT-1:0]   pin_a,
  input  logic [NEXT-1:0]   pin_b,
  input  logic [NSLOT-1:0]  src_main,
  input  logic [NSLOT-1:0]  src_alt,
  input  logic              brk_req,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              accept,
  input  logic              flag_set,
  input  logic              flag_clr,
  input  logic              flag_restore,
  input  logic              flag_restore_val,
  output logic              irq_pending,
  output logic              irq_is_brk,
  output logic [IDX_W-1:0]  irq_index,
  output logic              irq_block
);
  logic rst_n_s;

  irqc_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  // pin edge detection, first pins in the low half, second pins in the high half
  logic [2*NEXT-1:0] rise_all;

  irqc_pin_edge #(.W(2*NEXT)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .pin_raw ({pin_b, pin_a}),
    .rise    (rise_all)
  );

  // architectural state
  logic [NSLOT-1:0] req_q, req_d;
  logic [NSLOT-1:0] en_q,  en_d;
  logic [NSLOT-1:0] sel_q, sel_d;
  logic             pin_sel_q, pin_sel_d;
  logic             blk_q, blk_d;
  logic             req_ce, en_ce, sel_ce, cfg_ce, blk_ce;

  logic [NSLOT-1:0] slot_evt;

  irqc_src_route #(
    .NSLOT      (NSLOT),
    .SHARE_MASK (SHARE_MASK),
    .EXT_MASK   (EXT_MASK),
    .NEXT       (NEXT)
  ) u_route (
    .rise_a   (rise_all[NEXT-1:0]),
    .rise_b   (rise_all[2*NEXT-1:NEXT]),
    .pin_sel  (pin_sel_q),
    .src_main (src_main),
    .src_alt  (src_alt),
    .sel_q    (sel_q),
    .slot_evt (slot_evt)
  );

  logic [NSLOT-1:0] cand;
  logic             win_any;
  logic [IDX_W-1:0] win_idx;

  assign cand = req_q & en_q;

  irqc_prio #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_prio (
    .cand (cand),
    .any  (win_any),
    .idx  (win_idx)
  );

  // register port decode
  reg_addr_e addr_e;
  logic      wr_req, wr_en, wr_sel, wr_cfg;
  logic      take_slot;

  assign addr_e    = reg_addr_e'(reg_addr);
  assign wr_req    = reg_wr && (addr_e == RA_REQ);
  assign wr_en     = reg_wr && (addr_e == RA_EN);
  assign wr_sel    = reg_wr && (addr_e == RA_SEL);
  assign wr_cfg    = reg_wr && (addr_e == RA_CFG);
  assign take_slot = accept && win_any && !blk_q && !brk_req;

  // next-state logic
  always_comb begin
    req_d = req_q;
    if (wr_req) req_d = req_d & reg_wdata[NSLOT-1:0];
    if (take_slot) req_d[win_idx] = 1'b0;
    req_d  = req_d | slot_evt;
    req_ce = wr_req || take_slot || (|slot_evt);

    en_d  = reg_wdata[NSLOT-1:0];
    en_ce = wr_en;

    sel_d  = reg_wdata[NSLOT-1:0] & SHARE_MASK;
    sel_ce = wr_sel;

    pin_sel_d = reg_wdata[CFG_PINSEL_BIT];
    cfg_ce    = wr_cfg;

    blk_ce = 1'b1;
    if (accept)            blk_d = 1'b1;
    else if (flag_set)     blk_d = 1'b1;
    else if (flag_clr)     blk_d = 1'b0;
    else if (flag_restore) blk_d = flag_restore_val;
    else begin
      blk_d  = blk_q;
      blk_ce = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      req_q     <= '0;
      en_q      <= '0;
      sel_q     <= '0;
      pin_sel_q <= 1'b0;
      blk_q     <= 1'b1;
    end else begin
      if (req_ce) req_q     <= req_d;
      if (en_ce)  en_q      <= en_d;
      if (sel_ce) sel_q     <= sel_d;
      if (cfg_ce) pin_sel_q <= pin_sel_d;
      if (blk_ce) blk_q     <= blk_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    unique case (addr_e)
      RA_REQ: reg_rdata[NSLOT-1:0] = req_q;
      RA_EN:  reg_rdata[NSLOT-1:0] = en_q;
      RA_SEL: reg_rdata[NSLOT-1:0] = sel_q;
      RA_CFG: reg_rdata[CFG_PINSEL_BIT] = pin_sel_q;
      default: reg_rdata = '0;
    endcase
  end

  // outputs
  assign irq_block   = blk_q;
  assign irq_is_brk  = brk_req;
  assign irq_pending = brk_req || (win_any && !blk_q);
  assign irq_index   = win_idx;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned NSLOT = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSLOT-1:0] req_q,
  input logic [NSLOT-1:0] en_q,
  input logic [NSLOT-1:0] slot_evt,
  input logic             accept,
  input logic             flag_set,
  input logic             flag_clr,
  input logic             brk_req,
  input logic             irq_pending,
  input logic             irq_is_brk,
  input logic [IDX_W-1:0] irq_index,
  input logic             irq_block
);
  logic [NSLOT-1:0] below_win;
  assign below_win = (NSLOT'(1) << irq_index) - NSLOT'(1);

  AST_NO_SPONTANEOUS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q & ~$past(req_q) & ~$past(slot_evt)) == '0)); // R2

  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_evt) |=> ((req_q & $past(slot_evt)) == $past(slot_evt))); // R11

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> irq_block); // R5

  AST_BLOCK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !irq_is_brk) |-> !irq_block); // R4

  AST_BRK_PRESENTED: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (irq_pending && irq_is_brk)); // R4

  AST_WINNER_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !irq_is_brk) |->
      (req_q[irq_index] && en_q[irq_index] && ((req_q & en_q & below_win) == '0))); // R10

  AST_CLR_UNBLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !accept && !flag_set) |=> !irq_block); // R6
endmodule

bind irqc_top irqc_chk #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .req_q       (req_q),
  .en_q        (en_q),
  .slot_evt    (slot_evt),
  .accept      (accept),
  .flag_set    (flag_set),
  .flag_clr    (flag_clr),
  .brk_req     (brk_req),
  .irq_pending (irq_pending),
  .irq_is_brk  (irq_is_brk),
  .irq_index   (irq_index),
  .irq_block   (irq_block)
);

// File: tb/test_irqc_top.sv
module test_irqc_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] pin_a, pin_b;
  logic [7:0] src_main, src_alt;
  logic       brk_req;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       accept, flag_set, flag_clr, flag_restore, flag_restore_val;
  logic       irq_pending, irq_is_brk, irq_block;
  logic [2:0] irq_index;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irqc_top i_irqc_top (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
    .src_main(src_main), .src_alt(src_alt), .brk_req(brk_req),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .accept(accept), .flag_set(flag_set), .flag_clr(flag_clr),
    .flag_restore(flag_restore), .flag_restore_val(flag_restore_val),
    .irq_pending(irq_pending), .irq_is_brk(irq_is_brk),
    .irq_index(irq_index), .irq_block(irq_block)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [7:0] m, input logic [7:0] a);
    @(negedge clk);
    src_main = m; src_alt = a;
    @(negedge clk);
    src_main = '0; src_alt = '0;
  endtask

  task automatic flag_op(input logic acc, input logic s, input logic c, input logic r, input logic rv);
    @(negedge clk);
    accept = acc; flag_set = s; flag_clr = c; flag_restore = r; flag_restore_val = rv;
    @(negedge clk);
    accept = 0; flag_set = 0; flag_clr = 0; flag_restore = 0; flag_restore_val = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; pin_a = '0; pin_b = '0; src_main = '0; src_alt = '0; brk_req = 0;
    reg_addr = '0; reg_wr = 0; reg_wdata = '0;
    accept = 0; flag_set = 0; flag_clr = 0; flag_restore = 0; flag_restore_val = 0;
    #35 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    rd(2'd0, v); chk("R12 req", v, 8'h00);
    rd(2'd1, v); chk("R12 en", v, 8'h00);
    rd(2'd2, v); chk("R12 sel", v, 8'h00);
    rd(2'd3, v); chk("R12 cfg", v, 8'h00);
    chk("R12 block", irq_block, 1);
    chk("R12 pending", irq_pending, 0);

    // R2 writing ones cannot raise a request
    wr(2'd0, 8'hFF);
    rd(2'd0, v); chk("R2 write ones", v, 8'h00);

    // R1/R7/R8 sweep over slot, selection and source
    for (int s = 0; s < 8; s++) begin
      for (int sv = 0; sv < 2; sv++) begin
        for (int al = 0; al < 2; al++) begin
          bit shared, ext, hit;
          shared = (s < 5);
          ext    = (s == 0) || (s == 3);
          hit    = al ? (shared && sv) : (!ext && !(shared && sv));
          wr(2'd0, 8'h00);
          wr(2'd2, 8'(sv << s));
          rd(2'd2, v); chk("R7 sel readback", v, shared ? 8'(sv << s) : 8'h00);
          pulse(al ? 8'h00 : 8'(1 << s), al ? 8'(1 << s) : 8'h00);
          rd(2'd0, v); chk("R1 R7 R8 source route", v, hit ? 8'(1 << s) : 8'h00);
        end
      end
    end

    // R1 request holds over idle cycles
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h00);
    pulse(8'h80, 8'h00);
    repeat (5) @(negedge clk);
    rd(2'd0, v); chk("R1 hold", v, 8'h80);

    // R2 write zero clears selected bits only
    pulse(8'h60, 8'h00);
    wr(2'd0, 8'hBF);
    rd(2'd0, v); chk("R2 partial clear", v, 8'hA0);

    // R3 disabled request latches but is not presented
    wr(2'd1, 8'h00);
    flag_op(0, 0, 1, 0, 0);
    chk("R3 not presented", irq_pending, 0);
    rd(2'd0, v); chk("R3 latched", v, 8'hA0);
    wr(2'd1, 8'h5A);
    rd(2'd1, v); chk("R3 enable readback", v, 8'h5A);

    // R10 priority sweep over all enable patterns with all requests set
    wr(2'd2, 8'h1F);
    pulse(8'hE0, 8'h1F);
    rd(2'd0, v); chk("R10 all set", v, 8'hFF);
    chk("R10 flag low", irq_block, 0);
    for (int e = 0; e < 256; e++) begin
      int low;
      low = 0;
      for (int b = 7; b >= 0; b--) if (e[b]) low = b;
      wr(2'd1, 8'(e));
      chk("R10 pending", irq_pending, (e != 0));
      if (e != 0) chk("R10 index", irq_index, low);
    end

    // R4 flag blocks slots, break passes
    flag_op(0, 1, 0, 0, 0);
    wr(2'd1, 8'hFF);
    chk("R4 blocked", irq_pending, 0);
    @(negedge clk); brk_req = 1; #1;
    chk("R4 brk pending", irq_pending, 1);
    chk("R4 brk flag", irq_is_brk, 1);
    @(negedge clk); brk_req = 0;

    // R5 accept walks the requests in order
    for (int i = 0; i < 8; i++) begin
      flag_op(0, 0, 1, 0, 0);
      chk("R5 index", irq_index, i);
      flag_op(1, 0, 0, 0, 0);
      chk("R5 block after accept", irq_block, 1);
      rd(2'd0, v); chk("R5 cleared", v, 8'(8'hFF << (i + 1)));
    end

    // R5 accept of break clears no request
    pulse(8'h40, 8'h00);
    flag_op(0, 0, 1, 0, 0);
    @(negedge clk); brk_req = 1; accept = 1;
    @(negedge clk); brk_req = 0; accept = 0;
    rd(2'd0, v); chk("R5 brk keeps req", v, 8'h40);
    chk("R5 brk blocks", irq_block, 1);

    // R11 event beats software clear
    @(negedge clk);
    reg_addr = 2'd0; reg_wr = 1; reg_wdata = 8'h00; src_main = 8'h20;
    @(negedge clk);
    reg_wr = 0; src_main = 8'h00;
    rd(2'd0, v); chk("R11 set over write", v, 8'h20);

    // R11 event beats accept clear
    wr(2'd1, 8'h20);
    flag_op(0, 0, 1, 0, 0);
    chk("R11 index", irq_index, 5);
    @(negedge clk); accept = 1; src_main = 8'h20;
    @(negedge clk); accept = 0; src_main = 8'h00;
    rd(2'd0, v); chk("R11 set over accept", v, 8'h20);
    chk("R11 block", irq_block, 1);

    // R6 flag strobe ordering
    flag_op(0, 1, 1, 0, 0); chk("R6 set over clr", irq_block, 1);
    flag_op(0, 0, 1, 1, 1); chk("R6 clr over restore", irq_block, 0);
    flag_op(0, 0, 0, 1, 1); chk("R6 restore one", irq_block, 1);
    flag_op(0, 0, 0, 1, 0); chk("R6 restore zero", irq_block, 0);
    flag_op(1, 0, 1, 0, 0); chk("R6 accept over clr", irq_block, 1);

    // R9 pin latency and edge polarity
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h00);
    @(negedge clk); pin_a[0] = 1;
    @(negedge clk); rd(2'd0, v); chk("R9 one edge", v, 8'h00);
    @(negedge clk); rd(2'd0, v); chk("R9 two edges", v, 8'h00);
    @(negedge clk); rd(2'd0, v); chk("R9 three edges", v, 8'h01);
    wr(2'd0, 8'h00);
    @(negedge clk); pin_a[0] = 0;
    repeat (4) @(negedge clk);
    rd(2'd0, v); chk("R9 falling ignored", v, 8'h00);

    // R8 pin selection
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk("R8 cfg readback", v, 8'h40);
    @(negedge clk); pin_a[1] = 1;
    repeat (4) @(negedge clk);
    rd(2'd0, v); chk("R8 first pin ignored", v, 8'h00);
    @(negedge clk); pin_b[1] = 1; pin_b[0] = 1;
    repeat (4) @(negedge clk);
    rd(2'd0, v); chk("R8 second pins", v, 8'h09);

    done = 1'b1;
    finish_run();
  end
endmodule